// File: doc/BRIEF.md
# Region-Routed Block DMA Channel

This block is a single DMA channel. Software loads a source address, a destination address and a byte length into the channel's registers, sets a global operation word, and then writes a start command. If the launch checks pass, the channel reads system RAM one 32-bit beat at a time. Each beat goes to one of two downstream ports, and the destination address decides which one. The stream port receives every beat at one fixed address. The memory port receives the beats at a remapped address that grows with every byte moved.

Data moves in 32-byte bursts of eight beats. A new burst starts only after the last beat of the previous burst has been accepted. RAM reads use the source address masked to the RAM size. When a transfer runs past the end of RAM, the reads wrap to the start of RAM. When the transfer ends, the channel overwrites its registers in a fixed pattern and raises a one-cycle end interrupt.

Top module: `dma_region_chan`

## Requirements
- R1: A start write (word index 6, bit 0 = 1) launches a transfer only when the global operation register (index 3), ANDed with 0x00008207, equals 0x00008201. Any other value rejects the launch: busy stays low, no port moves data and no interrupt follows. Bits outside 0x8207 do not affect the check.
- R2: A launch is also rejected unless the length register (index 5) has its low five bits all zero.
- R3: A destination in 0x10000000..0x10FFFFFF routes the transfer to the stream port. The port receives length/4 beats in source order, and every beat carries the destination address unchanged. A transfer always ends on the eighth beat of a burst.
- R4: A destination in 0x11000000..0x11FFFFE0 routes the transfer to the memory port. Beat k goes to address {0xA4, destination[23:0]} + 4*k.
- R5: RAM read addresses are (source + 4*k) AND (RAM_BYTES-1). A transfer that runs past the last RAM byte continues from RAM address 0, and the beat order does not change.
- R6: Any other destination, including 0x13000000..0x13FFFFE0 and 0x11FFFFE1..0x11FFFFFF, moves no data. It sets bad_dest, which stays high until the next accepted launch. The completion sequence still runs, with the final source equal to source + length.
- R7: On completion, the source register (index 0) holds source + length. Bit 0 of the control register (index 1) is cleared and its other bits are kept. The count register (index 2) becomes 0.
- R8: On completion, the start register (index 6) and the length register become 0. The destination register (index 4) takes the final source value. irq is high for exactly one cycle per accepted launch.
- R9: After reset, all seven registers (index 0 source, 1 control, 2 count, 3 global operation, 4 destination, 5 length, 6 start) read 0, and busy, irq and bad_dest are low.
- R10: busy is high from an accepted launch until the cycle in which irq is high, and busy is low in that cycle. Register writes made while busy, including start writes, are ignored.
- R11: A launch with length 0 moves no data and still completes with irq and the register writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| ram_rd_valid | output | 1 | RAM beat read request |
| ram_rd_addr | output | 32 | Masked RAM byte address |
| ram_rd_ready | input | 1 | RAM accepts the request; data is valid in the same cycle |
| ram_rd_data | input | 32 | RAM read data |
| str_valid | output | 1 | Stream port beat valid |
| str_addr | output | 32 | Stream port address (fixed for the whole transfer) |
| str_data | output | 32 | Stream port data |
| str_ready | input | 1 | Stream port accepts the beat |
| mem_valid | output | 1 | Memory port beat valid |
| mem_addr | output | 32 | Memory port byte address |
| mem_data | output | 32 | Memory port data |
| mem_ready | input | 1 | Memory port accepts the beat |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Channel-end interrupt pulse |
| bad_dest | output | 1 | Last accepted launch had an unroutable destination |

## Verification
A wrong route decision shows up on the first beat: data appears on the wrong port or on no port at all. A wrong address step shows up within one beat as a stream address that moves or a memory address that skips. A bad RAM mask shows up only at the wrap beat, so directed transfers straddle the end of RAM. A wrong remaining-length count or a wrong burst counter shows up at the end of the transfer, as a wrong beat count, an early or late irq, or wrong written-back source and destination values. Broken launch gating shows up within a few cycles as busy or data on a rejected launch.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {RT_STREAM, RT_MEM, RT_NONE} route_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} mover_st_e;

  // launch gate on the global operation word
  localparam logic [31:0] GOP_MASK = 32'h0000_8207;
  localparam logic [31:0] GOP_WANT = 32'h0000_8201;

  // register word indices
  localparam logic [2:0] IDX_SRC   = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_COUNT = 3'd2;
  localparam logic [2:0] IDX_GOP   = 3'd3;
  localparam logic [2:0] IDX_DEST  = 3'd4;
  localparam logic [2:0] IDX_LEN   = 3'd5;
  localparam logic [2:0] IDX_START = 3'd6;

  function automatic logic gop_ok(input logic [31:0] g);
    return (g & GOP_MASK) == GOP_WANT;
  endfunction

  function automatic logic len_ok(input logic [31:0] len, input logic [31:0] burst_bytes);
    return (len & (burst_bytes - 32'd1)) == 32'd0;
  endfunction

  function automatic route_e classify(input logic [31:0] d);
    if (d[31:24] == 8'h10)                          return RT_STREAM;
    else if (d[31:24] == 8'h11 && d[23:0] <= 24'hFF_FFE0) return RT_MEM;
    else                                            return RT_NONE;
  endfunction

  function automatic logic [31:0] mem_remap(input logic [31:0] d);
    return {8'hA4, d[23:0]};
  endfunction

endpackage

// File: rtl/dma_route.sv
module dma_route
  import dma_chan_pkg::*;
(
  input  logic [31:0] dst_i,
  output route_e      route_o,
  output logic [31:0] mem_base_o
);
  assign route_o    = classify(dst_i);
  assign mem_base_o = mem_remap(dst_i);
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_chan_pkg::*;
#(
  parameter int unsigned RAM_BYTES   = 32'h0100_0000,
  parameter int unsigned BEAT_BYTES  = 4,
  parameter int unsigned BURST_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch_i,
  input  logic [31:0]             src_i,
  input  logic [31:0]             dst_i,
  input  logic [31:0]             len_i,
  input  route_e                  route_i,
  input  logic [31:0]             mem_base_i,
  output logic                    ram_valid_o,
  output logic [31:0]             ram_addr_o,
  input  logic                    ram_ready_i,
  input  logic [8*BEAT_BYTES-1:0] ram_data_i,
  output logic                    str_valid_o,
  output logic [31:0]             str_addr_o,
  output logic [8*BEAT_BYTES-1:0] str_data_o,
  input  logic                    str_ready_i,
  output logic                    mem_valid_o,
  output logic [31:0]             mem_addr_o,
  output logic [8*BEAT_BYTES-1:0] mem_data_o,
  input  logic                    mem_ready_i,
  output logic                    done_o,
  output logic [31:0]             src_final_o,
  output logic                    busy_o
);
  localparam int unsigned DW          = 8 * BEAT_BYTES;
  localparam int unsigned BURST_BEATS = BURST_BYTES / BEAT_BYTES;
  localparam int unsigned BW          = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [31:0] RAM_MASK    = 32'(RAM_BYTES - 1);
  localparam logic [31:0] STEP        = 32'(BEAT_BYTES);

  mover_st_e     state;
  route_e        rt;
  logic [31:0]   src_cur, dst_cur, remain;
  logic [BW-1:0] beat_idx;
  logic [DW-1:0] data_q;

  // named internal events
  logic sink_fire, last_beat;
  assign sink_fire = (state == ST_WRITE) &&
                     ((rt == RT_STREAM) ? str_ready_i : mem_ready_i);
  assign last_beat = sink_fire && (remain == STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rt       <= RT_NONE;
      src_cur  <= '0;
      dst_cur  <= '0;
      remain   <= '0;
      beat_idx <= '0;
      data_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch_i) begin
          rt       <= route_i;
          remain   <= len_i;
          beat_idx <= '0;
          dst_cur  <= (route_i == RT_MEM) ? mem_base_i : dst_i;
          if (route_i == RT_NONE || len_i == 32'd0) begin
            src_cur <= src_i + len_i;
            state   <= ST_DONE;
          end else begin
            src_cur <= src_i;
            state   <= ST_READ;
          end
        end
        ST_READ: if (ram_ready_i) begin
          data_q <= ram_data_i;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (sink_fire) begin
          src_cur  <= src_cur + STEP;
          remain   <= remain - STEP;
          beat_idx <= beat_idx + 1'b1;
          if (rt == RT_MEM) dst_cur <= dst_cur + STEP;
          state    <= last_beat ? ST_DONE : ST_READ;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ram_valid_o = (state == ST_READ);
  assign ram_addr_o  = src_cur & RAM_MASK;
  assign str_valid_o = (state == ST_WRITE) && (rt == RT_STREAM);
  assign str_addr_o  = dst_cur;
  assign str_data_o  = data_q;
  assign mem_valid_o = (state == ST_WRITE) && (rt == RT_MEM);
  assign mem_addr_o  = dst_cur;
  assign mem_data_o  = data_q;
  assign done_o      = (state == ST_DONE);
  assign src_final_o = src_cur;
  assign busy_o      = (state != ST_IDLE);

  // R3: a transfer only ends on the last beat of a whole burst
  a_r3_whole_bursts: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_idx == BW'(BURST_BEATS - 1));
  // R3: stream destination address never moves during a transfer
  a_r3_stream_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && rt == RT_STREAM && $past(state != ST_IDLE)) |-> $stable(dst_cur));
  // R4: memory address steps by one beat per accepted beat
  a_r4_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && rt == RT_MEM && $past(state == ST_WRITE)) |-> dst_cur == $past(dst_cur) + STEP);
  // R3/R4: at most one port is driven
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_valid_o, str_valid_o, mem_valid_o}));
endmodule

// File: rtl/dma_region_chan.sv
module dma_region_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned RAM_BYTES   = 32'h0100_0000,
  parameter int unsigned BEAT_BYTES  = 4,
  parameter int unsigned BURST_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        ram_rd_valid,
  output logic [31:0] ram_rd_addr,
  input  logic        ram_rd_ready,
  input  logic [31:0] ram_rd_data,
  output logic        str_valid,
  output logic [31:0] str_addr,
  output logic [31:0] str_data,
  input  logic        str_ready,
  output logic        mem_valid,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_data,
  input  logic        mem_ready,
  output logic        busy,
  output logic        irq,
  output logic        bad_dest
);
  logic [31:0] src_r, ctrl_r, cnt_r, gop_r, dst_r, len_r, start_r;
  logic        irq_q, bad_q;
  logic        wr_ok, launch, done;
  logic [31:0] src_final, mem_base;
  route_e      route;

  assign wr_ok  = reg_wr && !busy;
  assign launch = wr_ok && reg_addr == IDX_START && reg_wdata[0] &&
                  gop_ok(gop_r) && len_ok(len_r, 32'(BURST_BYTES));

  dma_route u_route (.dst_i(dst_r), .route_o(route), .mem_base_o(mem_base));

  dma_mover #(.RAM_BYTES(RAM_BYTES), .BEAT_BYTES(BEAT_BYTES), .BURST_BYTES(BURST_BYTES)) u_mover (
    .clk, .rst_n, .launch_i(launch), .src_i(src_r), .dst_i(dst_r), .len_i(len_r),
    .route_i(route), .mem_base_i(mem_base),
    .ram_valid_o(ram_rd_valid), .ram_addr_o(ram_rd_addr), .ram_ready_i(ram_rd_ready),
    .ram_data_i(ram_rd_data),
    .str_valid_o(str_valid), .str_addr_o(str_addr), .str_data_o(str_data), .str_ready_i(str_ready),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_ready),
    .done_o(done), .src_final_o(src_final), .busy_o(busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r <= '0; ctrl_r <= '0; cnt_r <= '0; gop_r <= '0;
      dst_r <= '0; len_r <= '0; start_r <= '0;
      irq_q <= 1'b0; bad_q <= 1'b0;
    end else begin
      irq_q <= done;
      if (launch) bad_q <= (route == RT_NONE);
      if (wr_ok) begin
        unique case (reg_addr)
          IDX_SRC:   src_r   <= reg_wdata;
          IDX_CTRL:  ctrl_r  <= reg_wdata;
          IDX_COUNT: cnt_r   <= reg_wdata;
          IDX_GOP:   gop_r   <= reg_wdata;
          IDX_DEST:  dst_r   <= reg_wdata;
          IDX_LEN:   len_r   <= reg_wdata;
          IDX_START: start_r <= reg_wdata;
          default: ;
        endcase
      end
      if (done) begin
        src_r     <= src_final;
        ctrl_r[0] <= 1'b0;
        cnt_r     <= '0;
        start_r   <= '0;
        len_r     <= '0;
        dst_r     <= src_final;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      IDX_SRC:   reg_rdata = src_r;
      IDX_CTRL:  reg_rdata = ctrl_r;
      IDX_COUNT: reg_rdata = cnt_r;
      IDX_GOP:   reg_rdata = gop_r;
      IDX_DEST:  reg_rdata = dst_r;
      IDX_LEN:   reg_rdata = len_r;
      IDX_START: reg_rdata = start_r;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq      = irq_q;
  assign bad_dest = bad_q;

  // R1: a transfer only begins under a passing global operation word
  a_r1_gop_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(gop_r) & GOP_MASK) == GOP_WANT);
  // R2: a transfer only begins with a whole-burst length
  a_r2_len_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(len_r[4:0]) == 5'd0);
  // R8: end interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10: busy has dropped when the interrupt shows
  a_r10_idle_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
  // R7: enable bit is clear when the interrupt shows
  a_r7_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctrl_r[0]);
endmodule

// File: tb/tb_dma_region_chan.sv
module tb_dma_region_chan;
  localparam int unsigned RAM_BYTES = 32'h0100_0000;
  localparam logic [31:0] MASK = 32'(RAM_BYTES - 1);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ram_rd_valid, ram_rd_ready = 0;
  logic [31:0] ram_rd_addr, ram_rd_data;
  logic str_valid, str_ready = 0, mem_valid, mem_ready = 0;
  logic [31:0] str_addr, str_data, mem_addr, mem_data;
  logic busy, irq, bad_dest;

  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0;
  int n_str = 0, n_mem = 0;
  logic [31:0] cap_addr [0:127];
  logic [31:0] cap_data [0:127];
  logic prev_irq = 0;
  int slow = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] ram_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h1};
  endfunction
  assign ram_rd_data = ram_word(ram_rd_addr);

  function automatic int region(input logic [31:0] d); // 0 stream 1 mem 2 none
    if (d >= 32'h1000_0000 && d <= 32'h10FF_FFFF) return 0;
    if (d >= 32'h1100_0000 && d <= 32'h11FF_FFE0) return 1;
    return 2;
  endfunction
  function automatic logic accepts(input logic [31:0] g, input logic [31:0] l);
    return ((g & 32'h8207) == 32'h8201) && (l % 32 == 0);
  endfunction

  dma_region_chan #(.RAM_BYTES(RAM_BYTES)) dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    ram_rd_ready = slow ? (($urandom % 3) == 0) : (($urandom % 4) != 0);
    str_ready    = slow ? (($urandom % 3) == 0) : (($urandom % 4) != 0);
    mem_ready    = ($urandom % 4) != 0;
    if (str_valid && str_ready && n_str < 128) begin
      cap_addr[n_str] = str_addr; cap_data[n_str] = str_data; n_str++;
    end
    if (mem_valid && mem_ready && n_mem < 128) begin
      cap_addr[n_mem] = mem_addr; cap_data[n_mem] = mem_data; n_mem++;
    end
    if (irq) irq_cnt++;
    if (irq && prev_irq) chk(0, "R8 irq width", 32'd2, 32'd1);
    if (irq && busy) chk(0, "R10 busy at irq", 32'd1, 32'd0);
    prev_irq = irq;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk); reg_addr = idx; #1; d = reg_rdata;
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l, input logic [31:0] g);
    n_str = 0; n_mem = 0; irq_cnt = 0;
    wr(3'd0, s); wr(3'd4, d); wr(3'd5, l); wr(3'd3, g);
    wr(3'd1, 32'h0000_1235); wr(3'd2, l >> 5); wr(3'd6, 32'd1);
  endtask

  task automatic finish_xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l, input logic [31:0] g);
    logic [31:0] v;
    int bad = 0, t = 0, reg_ok, nb;
    if (!accepts(g, l)) begin
      repeat (10) @(negedge clk);
      chk(!busy && irq_cnt == 0 && n_str == 0 && n_mem == 0,
          (l % 32 != 0) ? "R2 rejected length" : "R1 rejected gop", {busy, 31'(irq_cnt)}, 32'd0);
      return;
    end
    while (irq_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R8 one irq", irq_cnt, 1);
    rd(3'd0, v); chk(v == s + l, "R7 src writeback", v, s + l);
    rd(3'd1, v); chk(v == 32'h1234, "R7 ctrl bit0 cleared", v, 32'h1234);
    rd(3'd2, v); reg_ok = (v == 0);
    rd(3'd6, v); reg_ok &= (v == 0);
    rd(3'd5, v); reg_ok &= (v == 0);
    chk(reg_ok, "R7 R8 count/start/len cleared", reg_ok, 1);
    rd(3'd4, v); chk(v == s + l, "R8 dest takes final src", v, s + l);
    nb = l / 4;
    case (region(d))
      0: begin
        chk(n_str == nb && n_mem == 0, "R3 stream beat count", n_str, nb);
        for (int k = 0; k < n_str && k < nb; k++)
          if (cap_addr[k] != d || cap_data[k] != ram_word((s + 4*k) & MASK)) bad++;
        chk(bad == 0, "R3 R5 stream addr/data", bad, 0);
        chk(!bad_dest, "R6 bad_dest low", bad_dest, 0);
      end
      1: begin
        chk(n_mem == nb && n_str == 0, "R4 mem beat count", n_mem, nb);
        for (int k = 0; k < n_mem && k < nb; k++)
          if (cap_addr[k] != {8'hA4, d[23:0]} + 4*k || cap_data[k] != ram_word((s + 4*k) & MASK)) bad++;
        chk(bad == 0, "R4 R5 mem addr/data", bad, 0);
        chk(!bad_dest, "R6 bad_dest low", bad_dest, 0);
      end
      default: begin
        chk(n_str == 0 && n_mem == 0, "R6 no data", n_str + n_mem, 0);
        chk(bad_dest, "R6 bad_dest set", bad_dest, 1);
      end
    endcase
  endtask

  task automatic xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l, input logic [31:0] g);
    launch(s, d, l, g);
    finish_xfer(s, d, l, g);
  endtask

  initial begin
    logic [31:0] v, s, d, l, g;
    int ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ok = 1;
    for (int i = 0; i < 7; i++) begin rd(3'(i), v); if (v != 0) ok = 0; end
    chk(ok && !busy && !irq && !bad_dest, "R9 reset state", {ok[0], busy, irq, bad_dest}, 32'h8);

    xfer(32'h0C00_0100, 32'h1000_0040, 32'd64, 32'h8201);           // R3
    xfer(32'h0000_0200, 32'h11FF_FFE0, 32'd32, 32'h8201);           // R4 top of range
    xfer(32'h0000_0400, 32'h1112_3400, 32'd96, 32'h1234_8201);      // R1 outside-mask bits
    xfer(32'h00FF_FFC0, 32'h1000_0000, 32'd128, 32'h8201);          // R5 wrap stream
    xfer(32'h0CFF_FFE0, 32'h1100_0020, 32'd64, 32'h8201);           // R5 wrap mem
    xfer(32'h0000_1000, 32'h11FF_FFE4, 32'd32, 32'h8201);           // R6 just past mem range
    xfer(32'h0000_2000, 32'h1300_0000, 32'd64, 32'h8201);           // R6 second list region
    xfer(32'h0000_3000, 32'h1000_0000, 32'd0, 32'h8201);            // R11 zero length
    chk(irq_cnt == 1 && n_str == 0, "R11 zero length completes", irq_cnt, 1);
    xfer(32'h0, 32'h1000_0000, 32'd32, 32'h8200);                   // R1
    xfer(32'h0, 32'h1000_0000, 32'd32, 32'h8205);                   // R1
    xfer(32'h0, 32'h1000_0000, 32'd32, 32'h0201);                   // R1
    xfer(32'h0, 32'h1000_0000, 32'd48, 32'h8201);                   // R2
    xfer(32'h0, 32'h1100_0000, 32'd33, 32'h8201);                   // R2

    // R10: writes while busy are ignored
    slow = 1;
    launch(32'h0000_5000, 32'h1000_0080, 32'd256, 32'h8201);
    repeat (3) @(negedge clk);
    chk(busy, "R10 busy after launch", busy, 1);
    wr(3'd3, 32'h0); wr(3'd6, 32'd1);
    finish_xfer(32'h0000_5000, 32'h1000_0080, 32'd256, 32'h8201);
    slow = 0;
    rd(3'd3, v); chk(v == 32'h8201, "R10 gop write ignored while busy", v, 32'h8201);
    repeat (10) @(negedge clk);
    chk(irq_cnt == 1 && !busy, "R10 start while busy ignored", irq_cnt, 1);

    for (int i = 0; i < 30; i++) begin
      case ($urandom % 4)
        0, 3: d = 32'h1000_0000 | ($urandom & 32'h00FF_FFFF);
        1:    d = 32'h1100_0000 | ($urandom % 32'h00FF_FFE1);
        default: d = ($urandom % 2) ? (32'h1300_0000 | ($urandom & 32'hFF_FFFF)) : $urandom;
      endcase
      l = ($urandom % 9) * 32;
      if ($urandom % 8 == 0) l = l + 32'd8;
      s = ($urandom % 2) ? (32'h00FF_FF00 + ($urandom % 8) * 32) : ($urandom & 32'hFFFF_FFFC);
      g = ($urandom % 6 == 0) ? $urandom : (32'h8201 | ($urandom & ~32'h8207));
      xfer(s, d, l, g);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule